// File: doc/BRIEF.md
# Coherent Calendar Time Fetch Sequencer

This block reads the calendar time out of an external battery-backed clock chip. The chip has no latched multi-byte read, so a time value read one byte at a time can tear when the chip ticks between bytes. The block talks to the chip through a byte-transaction command port that feeds an I2C master. Each command carries a read/write flag, an 8-bit register address, 8-bit write data and a stop flag. The master answers with a done strobe, read data and an error flag.

On a start pulse the block first checks the chip's halt flag and, if the flag is set, clears it so the clock can run again. It then reads the time bank twice in full and compares the two passes. If they differ, it tries again, up to a bounded number of attempts. When it finishes, it presents binary seconds, minutes, hours, day of month, month and the full year, together with a one-cycle valid pulse. Any failed transaction abandons the fetch and raises a one-cycle error pulse instead.

Top module: `rtc_time_reader`

## Requirements
- R1: After synchronous active-low reset the block is idle. `busy_o`, `cmd_valid_o`, `time_valid_o` and `seq_err_o` are 0, and all time outputs are 0.
- R2: The first transaction after an accepted start reads address 0x0C with the stop flag clear.
- R3: If bit 6 of the byte read from 0x0C is 1, the next transaction writes that byte back to 0x0C with only bit 6 cleared and the stop flag clear. If bit 6 is 0, no write is issued.
- R4: The time bank is read with one transaction per byte, at addresses 0x00 up to 0x07 in ascending order. Every one of these transactions is a read with the stop flag set. One attempt consists of two such passes.
- R5: The two passes count as equal when these masked bytes match: 0x01&0x7F, 0x02&0x7F, 0x03&0x3F, 0x05&0x3F, 0x06&0x1F and all of 0x07. Bytes 0x00 and 0x04 are ignored. When the passes are equal, the fetch finishes.
- R6: When the passes differ, a new attempt starts, up to MAX_TRIES attempts (default 5) in total. After the last attempt the block reports that attempt's first-pass values, even if the passes still disagree.
- R7: Each output is decoded from BCD after masking. Seconds come from 0x01&0x7F, minutes from 0x02&0x7F, hours from 0x03&0x3F, day from 0x05&0x3F and month from 0x06&0x1F. The year is the BCD value of 0x07 plus BASE_YEAR (default 1970).
- R8: `time_valid_o` is a one-cycle pulse. It rises 2 cycles after the clock edge that completes the final time read. The time outputs change only in that same cycle.
- R9: If a transaction completes with its error flag set, the fetch ends at once. `seq_err_o` pulses for one cycle, starting the cycle after that edge. No further command is issued, no valid pulse follows, and the time outputs keep their values.
- R10: A start pulse while `busy_o` is 1 has no effect. One fetch produces exactly one sequence of transactions and one result.
- R11: A command stays asserted with a stable address and direction until the clock edge at which `cmd_valid_o` and `cmd_done_i` are both 1. That edge ends the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Single-cycle request to fetch the time |
| cmd_valid_o | output | 1 | Command present on the port |
| cmd_write_o | output | 1 | 1 = byte write, 0 = byte read |
| cmd_addr_o | output | 8 | Chip register address |
| cmd_wdata_o | output | 8 | Byte to write |
| cmd_stop_o | output | 1 | End the bus transfer with a stop |
| cmd_done_i | input | 1 | Transaction complete (one cycle) |
| cmd_rdata_i | input | 8 | Byte returned by a read, valid with done |
| cmd_err_i | input | 1 | Transaction failed, valid with done |
| busy_o | output | 1 | A fetch is in progress |
| time_valid_o | output | 1 | New time on the outputs (one cycle) |
| seq_err_o | output | 1 | Fetch abandoned on a bus error (one cycle) |
| sec_o | output | 7 | Seconds, binary |
| min_o | output | 7 | Minutes, binary |
| hour_o | output | 6 | Hours, binary |
| mday_o | output | 6 | Day of month, binary |
| month_o | output | 5 | Month, binary |
| year_o | output | 16 | Full year, binary |

## Verification
The valid pulse is due exactly 2 cycles after the edge that completes the last time read, and the error pulse 1 cycle after the edge that completes a failed transaction. The behavioural chip model records the cycle at which it returns each done, and the bench compares the pulse cycle against that record plus the expected latency. All outputs are sampled on the falling edge, so every register on the path has settled before it is read. Transaction counts, the address order and the chip's register contents are compared after each fetch has ended, and again some cycles later for the abort and busy-start cases. This shows that nothing further was issued.

// File: rtl/rtc_seq_pkg.sv
// Shared constants, state type and helpers for the time fetch sequencer.
// Assumes 8-bit chip registers and a time bank at addresses 0..REG_COUNT-1.
package rtc_seq_pkg;
    localparam int REG_COUNT = 8;
    localparam int IDX_W     = $clog2(REG_COUNT);
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int KEPT      = 6;

    localparam logic [ADDR_W-1:0] HALT_ADDR = 8'h0C;
    localparam int                HALT_BIT  = 6;

    // Slot order of the compared/decoded bytes.
    localparam int SLOT_SEC  = 0;
    localparam int SLOT_MIN  = 1;
    localparam int SLOT_HOUR = 2;
    localparam int SLOT_DAY  = 3;
    localparam int SLOT_MON  = 4;
    localparam int SLOT_YEAR = 5;

    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int DAY_W  = 6;
    localparam int MON_W  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALT_RD,
        ST_HALT_WR,
        ST_TREAD,
        ST_CMP
    } seq_state_t;

    // Chip address that feeds each kept slot.
    function automatic int slot_addr(input int slot);
        case (slot)
            SLOT_SEC:  return 1;
            SLOT_MIN:  return 2;
            SLOT_HOUR: return 3;
            SLOT_DAY:  return 5;
            SLOT_MON:  return 6;
            default:   return 7;
        endcase
    endfunction

    // Bits of each kept slot that carry time rather than control flags.
    function automatic logic [DATA_W-1:0] slot_mask(input int slot);
        case (slot)
            SLOT_SEC:  return 8'h7F;
            SLOT_MIN:  return 8'h7F;
            SLOT_HOUR: return 8'h3F;
            SLOT_DAY:  return 8'h3F;
            SLOT_MON:  return 8'h1F;
            default:   return 8'hFF;
        endcase
    endfunction

    // Two-digit packed BCD to binary.
    function automatic logic [DATA_W-1:0] bcd_to_bin(input logic [DATA_W-1:0] b);
        return ({4'b0000, b[7:4]} * 8'd10) + {4'b0000, b[3:0]};
    endfunction
endpackage

// File: rtl/rtc_seq_ctrl.sv
// Sequencer for the fetch: halt check/clear, two read passes per attempt,
// compare, retry. Drives the command port and the snapshot capture strobes.
// Assumes the responder answers each command with a one-cycle done.
module rtc_seq_ctrl
    import rtc_seq_pkg::*;
#(
    parameter int MAX_TRIES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmd_done_i,
    input  logic              cmd_err_i,
    input  logic [DATA_W-1:0] cmd_rdata_i,
    input  logic              match_i,
    output logic              cmd_valid_o,
    output logic              cmd_write_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [DATA_W-1:0] cmd_wdata_o,
    output logic              cmd_stop_o,
    output logic              cap_en_o,
    output logic              cap_pass_o,
    output logic [IDX_W-1:0]  cap_idx_o,
    output logic              finish_o,
    output logic              abort_o,
    output logic              busy_o
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REG_COUNT - 1);

    seq_state_t        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              pass_q;
    logic [TRY_W-1:0]  try_q;
    logic [DATA_W-1:0] wdata_q;
    logic              xfer_ok;

    // Command outputs follow the current state.
    always_comb begin
        cmd_valid_o = (state_q == ST_HALT_RD) || (state_q == ST_HALT_WR) ||
                      (state_q == ST_TREAD);
        cmd_write_o = (state_q == ST_HALT_WR);
        cmd_stop_o  = (state_q == ST_TREAD);
        cmd_addr_o  = (state_q == ST_TREAD) ? {{(ADDR_W-IDX_W){1'b0}}, idx_q} : HALT_ADDR;
        cmd_wdata_o = wdata_q;
    end

    // Handshake outcome, capture strobe and finish decision.
    always_comb begin
        xfer_ok    = cmd_valid_o && cmd_done_i && !cmd_err_i;
        abort_o    = cmd_valid_o && cmd_done_i && cmd_err_i;
        cap_en_o   = (state_q == ST_TREAD) && xfer_ok;
        cap_pass_o = pass_q;
        cap_idx_o  = idx_q;
        finish_o   = (state_q == ST_CMP) && (match_i || (try_q == LAST_TRY));
        busy_o     = (state_q != ST_IDLE);
    end

    // State, index, pass and attempt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pass_q  <= 1'b0;
            try_q   <= '0;
            wdata_q <= '0;
        end else if (abort_o) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_HALT_RD;
                    idx_q   <= '0;
                    pass_q  <= 1'b0;
                    try_q   <= '0;
                end
                ST_HALT_RD: if (xfer_ok) begin
                    if (cmd_rdata_i[HALT_BIT]) begin
                        wdata_q <= cmd_rdata_i & ~(DATA_W'(1) << HALT_BIT);
                        state_q <= ST_HALT_WR;
                    end else begin
                        state_q <= ST_TREAD;
                    end
                end
                ST_HALT_WR: if (xfer_ok) state_q <= ST_TREAD;
                ST_TREAD: if (xfer_ok) begin
                    if (idx_q == LAST_IDX) begin
                        idx_q <= '0;
                        if (pass_q) begin
                            pass_q  <= 1'b0;
                            state_q <= ST_CMP;
                        end else begin
                            pass_q <= 1'b1;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_CMP: begin
                    if (finish_o) begin
                        state_q <= ST_IDLE;
                    end else begin
                        try_q   <= try_q + 1'b1;
                        state_q <= ST_TREAD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rtc_snap_bank.sv
// Holds the kept time bytes of both read passes and flags whether the
// masked fields agree. Bytes that are never compared get no storage.
module rtc_snap_bank
    import rtc_seq_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cap_en_i,
    input  logic                         cap_pass_i,
    input  logic [IDX_W-1:0]             cap_idx_i,
    input  logic [DATA_W-1:0]            cap_data_i,
    output logic [KEPT-1:0][DATA_W-1:0]  first_o,
    output logic                         match_o
);
    logic [KEPT-1:0][DATA_W-1:0] second_q;
    logic [KEPT-1:0]             diff;

    for (genvar s = 0; s < KEPT; s++) begin : g_slot
        localparam logic [IDX_W-1:0]  ADDR = IDX_W'(slot_addr(s));
        localparam logic [DATA_W-1:0] MASK = slot_mask(s);

        // Capture this slot's byte into the pass it belongs to.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                first_o[s]  <= '0;
                second_q[s] <= '0;
            end else if (cap_en_i && (cap_idx_i == ADDR)) begin
                if (cap_pass_i) second_q[s] <= cap_data_i;
                else            first_o[s]  <= cap_data_i;
            end
        end

        // Slot disagrees only in its time-carrying bits.
        assign diff[s] = |((first_o[s] ^ second_q[s]) & MASK);
    end

    assign match_o = ~|diff;
endmodule

// File: rtl/rtc_time_decode.sv
// Masks the control flags out of the first-pass bytes and converts each
// BCD field to binary; the year adds a fixed base. Purely combinational.
module rtc_time_decode
    import rtc_seq_pkg::*;
#(
    parameter int BASE_YEAR = 1970,
    parameter int YEAR_W    = 16
) (
    input  logic [KEPT-1:0][DATA_W-1:0] raw_i,
    output logic [SEC_W-1:0]            sec_o,
    output logic [MIN_W-1:0]            min_o,
    output logic [HOUR_W-1:0]           hour_o,
    output logic [DAY_W-1:0]            mday_o,
    output logic [MON_W-1:0]            month_o,
    output logic [YEAR_W-1:0]           year_o
);
    logic [KEPT-1:0][DATA_W-1:0] bin;

    // Mask and convert every slot.
    always_comb begin
        for (int s = 0; s < KEPT; s++) begin
            bin[s] = bcd_to_bin(raw_i[s] & slot_mask(s));
        end
    end

    // Narrow each field to its output width and add the year base.
    always_comb begin
        sec_o   = bin[SLOT_SEC][SEC_W-1:0];
        min_o   = bin[SLOT_MIN][MIN_W-1:0];
        hour_o  = bin[SLOT_HOUR][HOUR_W-1:0];
        mday_o  = bin[SLOT_DAY][DAY_W-1:0];
        month_o = bin[SLOT_MON][MON_W-1:0];
        year_o  = YEAR_W'(bin[SLOT_YEAR]) + YEAR_W'(BASE_YEAR);
    end
endmodule

// File: rtl/rtc_time_reader.sv
// Top of the coherent time fetch: sequencer, snapshot bank and decoder,
// plus the registered result and pulse outputs.
// Assumes one outstanding command at a time on the port.
module rtc_time_reader
    import rtc_seq_pkg::*;
#(
    parameter int BASE_YEAR = 1970,
    parameter int MAX_TRIES = 5,
    parameter int YEAR_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              cmd_valid_o,
    output logic              cmd_write_o,
    output logic [7:0]        cmd_addr_o,
    output logic [7:0]        cmd_wdata_o,
    output logic              cmd_stop_o,
    input  logic              cmd_done_i,
    input  logic [7:0]        cmd_rdata_i,
    input  logic              cmd_err_i,
    output logic              busy_o,
    output logic              time_valid_o,
    output logic              seq_err_o,
    output logic [6:0]        sec_o,
    output logic [6:0]        min_o,
    output logic [5:0]        hour_o,
    output logic [5:0]        mday_o,
    output logic [4:0]        month_o,
    output logic [YEAR_W-1:0] year_o
);
    logic                        cap_en, cap_pass, match, finish, abort;
    logic [IDX_W-1:0]            cap_idx;
    logic [KEPT-1:0][DATA_W-1:0] first;
    logic [SEC_W-1:0]            d_sec;
    logic [MIN_W-1:0]            d_min;
    logic [HOUR_W-1:0]           d_hour;
    logic [DAY_W-1:0]            d_day;
    logic [MON_W-1:0]            d_mon;
    logic [YEAR_W-1:0]           d_year;

    rtc_seq_ctrl #(.MAX_TRIES(MAX_TRIES)) u_ctrl (
        .clk, .rst_n, .start_i,
        .cmd_done_i, .cmd_err_i, .cmd_rdata_i,
        .match_i(match),
        .cmd_valid_o, .cmd_write_o, .cmd_addr_o, .cmd_wdata_o, .cmd_stop_o,
        .cap_en_o(cap_en), .cap_pass_o(cap_pass), .cap_idx_o(cap_idx),
        .finish_o(finish), .abort_o(abort), .busy_o
    );

    rtc_snap_bank u_bank (
        .clk, .rst_n,
        .cap_en_i(cap_en), .cap_pass_i(cap_pass), .cap_idx_i(cap_idx),
        .cap_data_i(cmd_rdata_i),
        .first_o(first), .match_o(match)
    );

    rtc_time_decode #(.BASE_YEAR(BASE_YEAR), .YEAR_W(YEAR_W)) u_dec (
        .raw_i(first),
        .sec_o(d_sec), .min_o(d_min), .hour_o(d_hour),
        .mday_o(d_day), .month_o(d_mon), .year_o(d_year)
    );

    // Register the result and the one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_valid_o <= 1'b0;
            seq_err_o    <= 1'b0;
            sec_o        <= '0;
            min_o        <= '0;
            hour_o       <= '0;
            mday_o       <= '0;
            month_o      <= '0;
            year_o       <= '0;
        end else begin
            time_valid_o <= finish;
            seq_err_o    <= abort;
            if (finish) begin
                sec_o   <= d_sec;
                min_o   <= d_min;
                hour_o  <= d_hour;
                mday_o  <= d_day;
                month_o <= d_mon;
                year_o  <= d_year;
            end
        end
    end
endmodule

// File: rtl/rtc_time_reader_chk.sv
// Protocol and pulse checks for rtc_time_reader, attached by bind.
module rtc_time_reader_chk #(
    parameter int YEAR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid_o,
    input logic              cmd_write_o,
    input logic [7:0]        cmd_addr_o,
    input logic [7:0]        cmd_wdata_o,
    input logic              cmd_stop_o,
    input logic              cmd_done_i,
    input logic              busy_o,
    input logic              time_valid_o,
    input logic              seq_err_o,
    input logic [6:0]        sec_o,
    input logic [6:0]        min_o,
    input logic [5:0]        hour_o,
    input logic [5:0]        mday_o,
    input logic [4:0]        month_o,
    input logic [YEAR_W-1:0] year_o
);
    AST_HALT_RD_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_addr_o == 8'h0C) |-> !cmd_stop_o); // R2
    AST_HALT_WR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_write_o) |-> (cmd_addr_o == 8'h0C && (cmd_wdata_o & 8'h40) == 8'h00)); // R3
    AST_TIME_RD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_addr_o < 8'd8) |-> (cmd_stop_o && !cmd_write_o)); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        time_valid_o |=> !time_valid_o); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !time_valid_o |-> $stable({sec_o, min_o, hour_o, mday_o, month_o, year_o})); // R8
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err_o |=> !seq_err_o); // R9
    AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err_o |-> (!time_valid_o && !busy_o)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cmd_valid_o); // R10
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_done_i) |=> (cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_write_o))); // R11
endmodule

bind rtc_time_reader rtc_time_reader_chk #(.YEAR_W(YEAR_W)) u_chk (.*);

// File: tb/rtc_time_reader_bench.sv
// Directed bench with a behavioural clock chip on the command port.
module rtc_time_reader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cmd_valid_o, cmd_write_o, cmd_stop_o;
    logic [7:0]  cmd_addr_o, cmd_wdata_o;
    logic        cmd_done_i = 1'b0;
    logic [7:0]  cmd_rdata_i = 8'h00;
    logic        cmd_err_i = 1'b0;
    logic        busy_o, time_valid_o, seq_err_o;
    logic [6:0]  sec_o, min_o;
    logic [5:0]  hour_o, mday_o;
    logic [4:0]  month_o;
    logic [15:0] year_o;

    always #2 clk = ~clk;

    rtc_time_reader u_rtc_time_reader (.*);

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Chip model state and statistics.
    logic [7:0] regs [16];
    int n_txn, n_time_rd, n_halt_wr, n_order_bad, n_hold_bad;
    int done_cyc, err_at, bump_at, stream_on, stream_base, stream_n;
    logic [7:0] bump_val;
    logic [7:0] first_addr;
    logic       first_write, first_stop;
    int n_valid, n_err, valid_cyc, err_cyc;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    // Responder: latch a command, answer two cycles later with a done.
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_valid_o) begin
                logic [7:0] a;
                logic       w;
                a = cmd_addr_o;
                w = cmd_write_o;
                @(negedge clk);
                if (cmd_addr_o != a || cmd_write_o != w || !cmd_valid_o) n_hold_bad++;
                n_txn++;
                if (n_txn == 1) begin
                    first_addr  = a;
                    first_write = w;
                    first_stop  = cmd_stop_o;
                end
                if (n_txn == err_at) cmd_err_i = 1'b1;
                if (w) begin
                    regs[a[3:0]] = cmd_wdata_o;
                    n_halt_wr++;
                end else if (a < 8'd8) begin
                    if (a != 8'(n_time_rd % 8) || !cmd_stop_o) n_order_bad++;
                    if (bump_at != 0 && n_time_rd + 1 == bump_at) regs[1] = bump_val;
                    if (stream_on != 0 && a == 8'd1) begin
                        stream_n++;
                        regs[1] = to_bcd(stream_base + stream_n);
                    end
                    n_time_rd++;
                end
                cmd_rdata_i = regs[a[3:0]];
                cmd_done_i  = 1'b1;
                done_cyc    = cyc;
                @(negedge clk);
                cmd_done_i = 1'b0;
                cmd_err_i  = 1'b0;
            end
        end
    end

    // Pulse monitor.
    always @(negedge clk) begin
        if (time_valid_o) begin n_valid++; valid_cyc = cyc; end
        if (seq_err_o)    begin n_err++;   err_cyc   = cyc; end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        n_txn = 0; n_time_rd = 0; n_halt_wr = 0; n_order_bad = 0; n_hold_bad = 0;
        err_at = 0; bump_at = 0; stream_on = 0; stream_n = 0;
        n_valid = 0; n_err = 0; valid_cyc = -1; err_cyc = -1; done_cyc = -1;
    endtask

    task automatic load_time(input logic [7:0] cs, input logic [7:0] s, input logic [7:0] m,
                             input logic [7:0] h, input logic [7:0] d, input logic [7:0] mo,
                             input logic [7:0] y, input logic [7:0] halt);
        regs[0] = cs; regs[1] = s; regs[2] = m; regs[3] = h;
        regs[4] = 8'h05; regs[5] = d; regs[6] = mo; regs[7] = y;
        regs[12] = halt;
    endtask

    task automatic fetch_and_wait();
        int t;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        t = 0;
        while (n_valid == 0 && n_err == 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(busy_o == 0 && cmd_valid_o == 0, "R1", "idle after reset", busy_o, 0);
        chk(time_valid_o == 0 && seq_err_o == 0, "R1", "pulses low", time_valid_o, 0);
        chk(sec_o == 0 && year_o == 0 && month_o == 0, "R1", "outputs zero", year_o, 0);
    endtask

    task automatic t_basic();
        clear_stats();
        load_time(8'h42, 8'h59, 8'h07, 8'h23, 8'h31, 8'h12, 8'h99, 8'h05);
        fetch_and_wait();
        chk(first_addr == 8'h0C && !first_write && !first_stop, "R2", "halt probe", first_addr, 12);
        chk(n_halt_wr == 0, "R3", "no write when flag clear", n_halt_wr, 0);
        chk(n_time_rd == 16 && n_order_bad == 0, "R4", "two ascending passes", n_time_rd, 16);
        chk(n_valid == 1, "R5", "single result on agreement", n_valid, 1);
        chk(sec_o == 59 && min_o == 7 && hour_o == 23, "R7", "sec", sec_o, 59);
        chk(mday_o == 31 && month_o == 12, "R7", "day", mday_o, 31);
        chk(year_o == 2069, "R7", "year", year_o, 2069);
        chk(valid_cyc == done_cyc + 2, "R8", "valid latency", valid_cyc - done_cyc, 2);
        chk(n_hold_bad == 0, "R11", "command held", n_hold_bad, 0);
    endtask

    task automatic t_halt_masks();
        clear_stats();
        load_time(8'h10, 8'hD9, 8'hC5, 8'hC8, 8'hC1, 8'hE2, 8'h00, 8'hC5);
        fetch_and_wait();
        chk(n_halt_wr == 1, "R3", "one halt write", n_halt_wr, 1);
        chk(regs[12] == 8'h85, "R3", "halt bit cleared only", regs[12], 8'h85);
        chk(n_txn == 18, "R3", "transaction count", n_txn, 18);
        chk(sec_o == 59 && min_o == 45 && hour_o == 8, "R7", "masked sec", sec_o, 59);
        chk(mday_o == 1 && month_o == 2 && year_o == 1970, "R7", "masked date", year_o, 1970);
    endtask

    task automatic t_retry_once();
        clear_stats();
        load_time(8'h00, 8'h30, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h00);
        bump_at  = 10;
        bump_val = 8'h31;
        fetch_and_wait();
        chk(n_time_rd == 32, "R6", "one retry", n_time_rd, 32);
        chk(sec_o == 31, "R6", "retry result", sec_o, 31);
        chk(n_valid == 1, "R5", "single pulse", n_valid, 1);
        chk(valid_cyc == done_cyc + 2, "R8", "valid latency retry", valid_cyc - done_cyc, 2);
    endtask

    task automatic t_never_agree();
        clear_stats();
        load_time(8'h00, 8'h10, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h00);
        stream_on   = 1;
        stream_base = 10;
        fetch_and_wait();
        chk(n_time_rd == 80, "R6", "five attempts", n_time_rd, 80);
        chk(sec_o == 19, "R6", "last first-pass value", sec_o, 19);
        chk(n_valid == 1 && n_order_bad == 0, "R4", "order over attempts", n_order_bad, 0);
    endtask

    task automatic t_bus_error();
        clear_stats();
        load_time(8'h00, 8'h44, 8'h44, 8'h04, 8'h04, 8'h04, 8'h44, 8'h00);
        err_at = 4;
        fetch_and_wait();
        repeat (30) @(negedge clk);
        chk(n_err == 1 && n_valid == 0, "R9", "error pulse only", n_err, 1);
        chk(err_cyc == done_cyc + 1, "R9", "error latency", err_cyc - done_cyc, 1);
        chk(n_txn == 4 && busy_o == 0, "R9", "no command after abort", n_txn, 4);
        chk(sec_o == 19 && year_o == 1975, "R9", "outputs kept", sec_o, 19);
    endtask

    task automatic t_start_busy();
        int t;
        clear_stats();
        load_time(8'h00, 8'h12, 8'h34, 8'h11, 8'h22, 8'h09, 8'h24, 8'h00);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy_o == 1, "R10", "busy mid-fetch", busy_o, 1);
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        t = 0;
        while (n_valid == 0 && t < 3000) begin @(negedge clk); t++; end
        repeat (60) @(negedge clk);
        chk(n_txn == 17 && n_valid == 1, "R10", "second start ignored", n_txn, 17);
        chk(sec_o == 12 && min_o == 34 && year_o == 1994, "R10", "result intact", year_o, 1994);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 8'h00;
        clear_stats();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_halt_masks();
        t_retry_once();
        t_never_agree();
        t_bus_error();
        t_start_busy();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule